// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits on the address path of a DMA engine and sorts each outgoing 32-bit request address into one of a small number of programmable memory windows (four by default). Every window is described by a base register, whose upper half is the window's base address and whose bits 15:8 are a target attribute, and by a size register, whose upper half is a mask of the address bits the window ignores. A shared control register holds one enable bit per window and a 2-bit access-permission field per window.

For each request the decoder reports one of three outcomes in the same cycle: a hit, a miss, or a protection violation. On a hit it also gives the winning window index, the target attribute, and an active-low one-hot chip-select vector. When more than one window matches, the window with the lowest index wins. A word-indexed register port programs and reads back the windows. The configuration is registered and the decode from address to result is purely combinational.

Top module: `dma_win_decoder`

## Requirements
- R1: After reset every window is disabled and every configuration register reads 0, so a valid request reports a miss.
- R2: Register index 0 selects the control register, indices 1..4 select the base registers of windows 0..3, and indices 5..8 select the size registers of windows 0..3. Base and size registers store and read back all 32 bits. The control register keeps only bits 3:0 (window enables) and bits 23:16 (access fields), and all other bits read 0. Indices above 8 read 0 and writes to them change nothing. A write takes effect on the decode from the cycle after its clock edge.
- R3: An enabled window matches when the address bits 31:16, with the size mask bits 31:16 cleared, equal the base bits 31:16 with the same mask bits cleared. Address bits 15:0 never affect the decode.
- R4: A window whose enable bit (control bit i for window i) is 0 never matches.
- R5: When several enabled windows match, the lowest-indexed one is selected.
- R6: The access field of window i is control bits 17+2i:16+2i. A read needs bit 0 of the field and a write needs bit 1. If the selected window denies the access, prot_err is 1, and win_hit is 0 with no attribute or chip select driven.
- R7: On a hit, win_idx is the selected window, tgt_attr is bits 15:8 of its base register, and cs_n is all ones except a 0 at the selected window's position.
- R8: When no enabled window matches a valid request, win_miss is 1, win_hit and prot_err are 0, tgt_attr is 0, win_idx is 0, and cs_n is all ones.
- R9: With req_valid low, win_hit, win_miss and prot_err are all 0, tgt_attr and win_idx are 0, and cs_n is all ones, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Request address is valid |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | 32 | Request address |
| win_hit | output | 1 | An allowed window was selected |
| win_miss | output | 1 | No enabled window matched |
| prot_err | output | 1 | Selected window denies this access |
| win_idx | output | 2 | Index of the selected window |
| tgt_attr | output | 8 | Target attribute of the selected window |
| cs_n | output | 4 | Active-low one-hot chip select |

## Verification
The main decode is tried with a memory map of unequal windows (2 GB, 1 GB, 64 KB and a catch-all), probing addresses at window edges and just outside them, which separates a correct mask compare from one that uses the wrong bits or ignores the mask. The catch-all window is first left disabled and then enabled over the others, which tells the enable gating apart from the lowest-index priority. Read-only and write-only permission settings are each crossed with reads and writes, so that a swapped permission bit or an attribute leaking through a violation shows up. Idle requests aimed at a matching address check that nothing is driven without req_valid.

// File: rtl/dwd_pkg.sv
`timescale 1ns/1ps
package dwd_pkg;

  // Kind of register addressed on the configuration port
  typedef enum logic [1:0] {
    RK_CTRL = 2'd0,
    RK_BASE = 2'd1,
    RK_SIZE = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  // Upper half of an address compared against a window
  localparam int HI_W   = 16;
  localparam int ATTR_W = 8;
  localparam int ATTR_LSB = 8;
  localparam int ACC_LSB  = 16;

  // Window compare: masked bits of the size register are ignored
  function automatic logic win_compare(input logic [HI_W-1:0] addr_hi,
                                       input logic [HI_W-1:0] base_hi,
                                       input logic [HI_W-1:0] mask_hi);
    return ((addr_hi & ~mask_hi) == (base_hi & ~mask_hi));
  endfunction

  // Permission: bit 0 grants reads, bit 1 grants writes
  function automatic logic access_allowed(input logic [1:0] acc,
                                          input logic       is_write);
    return is_write ? acc[1] : acc[0];
  endfunction

  // Register index decode: 0 control, 1..n base, n+1..2n size
  function automatic reg_kind_e reg_kind(input int unsigned idx,
                                         input int unsigned n_win);
    if (idx == 0)            return RK_CTRL;
    else if (idx <= n_win)   return RK_BASE;
    else if (idx <= 2*n_win) return RK_SIZE;
    else                     return RK_NONE;
  endfunction

  // Bits of the control register that are implemented
  function automatic logic [31:0] ctrl_mask(input int unsigned n_win);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(n_win)) begin
        m[i]               = 1'b1;
        m[ACC_LSB + 2*i]   = 1'b1;
        m[ACC_LSB + 2*i+1] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dwd_cfg_regs.sv
`timescale 1ns/1ps
module dwd_cfg_regs
  import dwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_WIN-1:0]        en,
  output logic [2*NUM_WIN-1:0]      acc,
  output logic [NUM_WIN*DATA_W-1:0] base_flat,
  output logic [NUM_WIN*DATA_W-1:0] size_flat
);

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(ctrl_mask(NUM_WIN));

  reg_kind_e           kind;
  int unsigned         sel_u;
  logic [DATA_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]   base_q [NUM_WIN];
  logic [DATA_W-1:0]   size_q [NUM_WIN];

  assign sel_u = int'(sel);
  assign kind  = reg_kind(sel_u, NUM_WIN);

  // Control register keeps only the implemented bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ctrl_q <= '0;
    else if (we && kind == RK_CTRL)  ctrl_q <= wdata & CTRL_MASK;
  end

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win_regs
      localparam int unsigned BASE_IDX = g + 1;
      localparam int unsigned SIZE_IDX = g + 1 + NUM_WIN;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         base_q[g] <= '0;
        else if (we && sel_u == BASE_IDX)   base_q[g] <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         size_q[g] <= '0;
        else if (we && sel_u == SIZE_IDX)   size_q[g] <= wdata;
      end

      assign en[g]                          = ctrl_q[g];
      assign acc[2*g +: 2]                  = ctrl_q[ACC_LSB + 2*g +: 2];
      assign base_flat[g*DATA_W +: DATA_W]  = base_q[g];
      assign size_flat[g*DATA_W +: DATA_W]  = size_q[g];
    end
  endgenerate

  // Readback of the selected register
  always_comb begin
    rdata = '0;
    unique case (kind)
      RK_CTRL: rdata = ctrl_q;
      RK_BASE: begin
        for (int i = 0; i < NUM_WIN; i++)
          if (sel_u == unsigned'(i + 1)) rdata = base_q[i];
      end
      RK_SIZE: begin
        for (int i = 0; i < NUM_WIN; i++)
          if (sel_u == unsigned'(i + 1 + NUM_WIN)) rdata = size_q[i];
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/dwd_win_match.sv
`timescale 1ns/1ps
module dwd_win_match
  import dwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32
) (
  input  logic [HI_W-1:0]           addr_hi,
  input  logic [NUM_WIN-1:0]        en,
  input  logic [NUM_WIN*DATA_W-1:0] base_flat,
  input  logic [NUM_WIN*DATA_W-1:0] size_flat,
  output logic [NUM_WIN-1:0]        match
);

  localparam int HI_LSB = DATA_W - HI_W;

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      logic [HI_W-1:0] base_hi;
      logic [HI_W-1:0] mask_hi;
      assign base_hi  = base_flat[g*DATA_W + HI_LSB +: HI_W];
      assign mask_hi  = size_flat[g*DATA_W + HI_LSB +: HI_W];
      assign match[g] = en[g] & win_compare(addr_hi, base_hi, mask_hi);
    end
  endgenerate

endmodule

// File: rtl/dwd_prio_sel.sv
`timescale 1ns/1ps
module dwd_prio_sel #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_WIN-1:0] grant
);

  // Scan from the top so the lowest index is the last to be taken
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = NUM_WIN'(1) << i;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/dma_win_decoder.sv
`timescale 1ns/1ps
module dma_win_decoder
  import dwd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = $clog2(2*NUM_WIN + 1),
  parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_addr,
  output logic               win_hit,
  output logic               win_miss,
  output logic               prot_err,
  output logic [IDX_W-1:0]   win_idx,
  output logic [ATTR_W-1:0]  tgt_attr,
  output logic [NUM_WIN-1:0] cs_n
);

  logic [NUM_WIN-1:0]        win_en;
  logic [2*NUM_WIN-1:0]      win_acc;
  logic [NUM_WIN*DATA_W-1:0] base_flat;
  logic [NUM_WIN*DATA_W-1:0] size_flat;

  // Named internal events, visible to the checker
  logic [NUM_WIN-1:0] match_vec;
  logic [NUM_WIN-1:0] grant_vec;
  logic               any_match;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_allowed;
  logic [ATTR_W-1:0]  sel_attr;
  logic [15:0]        unused_addr_lo;

  assign unused_addr_lo = req_addr[15:0];

  dwd_cfg_regs #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .en        (win_en),
    .acc       (win_acc),
    .base_flat (base_flat),
    .size_flat (size_flat)
  );

  dwd_win_match #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_match (
    .addr_hi   (req_addr[DATA_W-1 -: HI_W]),
    .en        (win_en),
    .base_flat (base_flat),
    .size_flat (size_flat),
    .match     (match_vec)
  );

  dwd_prio_sel #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W)
  ) u_prio (
    .req   (match_vec),
    .any   (any_match),
    .idx   (sel_idx),
    .grant (grant_vec)
  );

  // Permission and attribute of the selected window
  always_comb begin
    sel_allowed = 1'b0;
    sel_attr    = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant_vec[i]) begin
        sel_allowed = access_allowed(win_acc[2*i +: 2], req_write);
        sel_attr    = base_flat[i*DATA_W + ATTR_LSB +: ATTR_W];
      end
    end
  end

  always_comb begin
    win_hit  = req_valid &  any_match &  sel_allowed;
    win_miss = req_valid & ~any_match;
    prot_err = req_valid &  any_match & ~sel_allowed;
    win_idx  = win_hit ? sel_idx  : '0;
    tgt_attr = win_hit ? sel_attr : '0;
    cs_n     = win_hit ? ~grant_vec : '1;
  end

endmodule

// File: rtl/dwd_checker.sv
`timescale 1ns/1ps
module dwd_checker #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               req_valid,
  input logic               win_hit,
  input logic               win_miss,
  input logic               prot_err,
  input logic [IDX_W-1:0]   win_idx,
  input logic [7:0]         tgt_attr,
  input logic [NUM_WIN-1:0] cs_n,
  input logic [NUM_WIN-1:0] match_vec
);

  // Exactly one outcome per valid request
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({win_hit, win_miss, prot_err}) == 1);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!win_hit && !win_miss && !prot_err && &cs_n && tgt_attr == 8'h0));

  // A hit drives one chip select, at the reported index
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ($countones(~cs_n) == 1 && cs_n[win_idx] == 1'b0));

  p_no_cs_without_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (&cs_n && tgt_attr == 8'h0));

  // No lower-indexed window matched than the one chosen
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ((match_vec & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0));

  p_miss_means_no_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_miss |-> match_vec == '0);

  // Register contents move only on a write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(cfg_sel)) |-> $stable(cfg_rdata));

endmodule

bind dma_win_decoder dwd_checker #(
  .NUM_WIN (NUM_WIN),
  .DATA_W  (DATA_W),
  .SEL_W   (SEL_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .win_hit   (win_hit),
  .win_miss  (win_miss),
  .prot_err  (prot_err),
  .win_idx   (win_idx),
  .tgt_attr  (tgt_attr),
  .cs_n      (cs_n),
  .match_vec (match_vec)
);

// File: tb/sim_dma_win_decoder.sv
`timescale 1ns/1ps
module sim_dma_win_decoder;

  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        win_hit, win_miss, prot_err;
  logic [1:0]  win_idx;
  logic [7:0]  tgt_attr;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [16:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // Bench-side copy of the programmed map
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_base [NW];
  logic [31:0] m_size [NW];

  always #10 clk = ~clk;

  dma_win_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .win_hit(win_hit),
    .win_miss(win_miss), .prot_err(prot_err), .win_idx(win_idx),
    .tgt_attr(tgt_attr), .cs_n(cs_n)
  );

  // Packing: {hit, miss, prot, idx[1:0], attr[7:0], cs_n[3:0]}
  function automatic logic [16:0] predict(logic v, logic wr, logic [31:0] a);
    int          w;
    logic [1:0]  pf;
    w = -1;
    for (int i = 0; i < NW; i++)
      if (w < 0 && m_ctrl[i] && (((a[31:16] ^ m_base[i][31:16]) & ~m_size[i][31:16]) == 16'h0))
        w = i;
    if (!v)    return {3'b000, 2'b00, 8'h00, 4'hF};
    if (w < 0) return {3'b010, 2'b00, 8'h00, 4'hF};
    pf = m_ctrl[16 + 2*w +: 2];
    if (!(wr ? pf[1] : pf[0])) return {3'b001, 2'b00, 8'h00, 4'hF};
    return {3'b100, 2'(w), m_base[w][15:8], ~(4'b0001 << w)};
  endfunction

  task automatic wr_cfg(input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 4'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx == 0) m_ctrl = d & 32'h00FF_000F;
    else if (idx <= NW) m_base[idx-1] = d;
    else if (idx <= 2*NW) m_size[idx-1-NW] = d;
  endtask

  task automatic rd_cfg(input int idx, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_sel = 4'(idx);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, cfg_rdata, exp);
    end
  endtask

  // Driver: applies a request and queues its prediction
  task automatic drive_req(input logic v, input logic wr, input logic [31:0] a, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = v; req_write = wr; req_addr = a;
    e.v = predict(v, wr, a);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        logic [16:0] act;
        e = sb.pop_front();
        act = {win_hit, win_miss, prot_err, win_idx, tgt_attr, cs_n};
        checks++;
        if (act !== e.v) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", e.tag, req_addr, act, e.v);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_base[i] = '0; m_size[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i <= 2*NW; i++) rd_cfg(i, 32'h0, "R1 reset reg");
    drive_req(1'b1, 1'b0, 32'h0000_0000, "R1 miss after reset");

    // R2: implemented control bits, out-of-range index
    wr_cfg(0, 32'hFFFF_FFFF);
    rd_cfg(0, 32'h00FF_000F, "R2 ctrl mask");
    wr_cfg(12, 32'h1234_5678);
    rd_cfg(12, 32'h0, "R2 out of range");
    wr_cfg(0, 32'h0);
    rd_cfg(0, 32'h0, "R2 ctrl clear");

    // Unequal windows; window 3 covers everything but starts disabled
    wr_cfg(1, 32'h0000_0E00); wr_cfg(5, 32'h7FFF_0000);
    wr_cfg(2, 32'h8000_0D00); wr_cfg(6, 32'h3FFF_0000);
    wr_cfg(3, 32'hC000_0B00); wr_cfg(7, 32'h0000_0000);
    wr_cfg(4, 32'h0000_0700); wr_cfg(8, 32'hFFFF_0000);
    rd_cfg(2, 32'h8000_0D00, "R2 base readback");
    rd_cfg(6, 32'h3FFF_0000, "R2 size readback");
    wr_cfg(0, 32'h00FF_0007);

    drive_req(1'b1, 1'b0, 32'h1234_5678, "R3 R7 window0");
    drive_req(1'b1, 1'b0, 32'h7FFF_FFFF, "R3 window0 top");
    drive_req(1'b1, 1'b1, 32'h8000_0000, "R3 R7 window1 base");
    drive_req(1'b1, 1'b0, 32'hBFFF_FFFF, "R3 window1 top");
    drive_req(1'b1, 1'b0, 32'hC000_ABCD, "R3 low bits ignored");
    drive_req(1'b1, 1'b0, 32'hC001_0000, "R4 R8 miss window3 off");
    drive_req(1'b1, 1'b1, 32'hFFFF_0000, "R8 miss top");

    // R4, R5: enabling the catch-all window
    wr_cfg(0, 32'h00FF_000F);
    drive_req(1'b1, 1'b0, 32'hC001_0000, "R4 window3 enabled");
    drive_req(1'b1, 1'b0, 32'h1000_0000, "R5 window0 over window3");
    drive_req(1'b1, 1'b1, 32'hC000_0000, "R5 window2 over window3");

    // R6: read-only, then write-only window 0
    wr_cfg(0, 32'h00FD_000F);
    drive_req(1'b1, 1'b1, 32'h1000_0000, "R6 write denied");
    drive_req(1'b1, 1'b0, 32'h1000_0000, "R6 read allowed");
    wr_cfg(0, 32'h00FE_000F);
    drive_req(1'b1, 1'b0, 32'h1000_0000, "R6 read denied");
    drive_req(1'b1, 1'b1, 32'h1000_0000, "R6 write allowed");

    // R5: window 0 off, window 3 takes over
    wr_cfg(0, 32'h00FE_000E);
    drive_req(1'b1, 1'b0, 32'h1000_0000, "R5 R4 window3 after window0 off");

    // R9: idle requests
    drive_req(1'b0, 1'b0, 32'h1000_0000, "R9 idle read");
    drive_req(1'b0, 1'b1, 32'h8000_0000, "R9 idle write");

    @(posedge clk); #1 req_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule